// File: doc/BRIEF.md
# Four-Channel Countdown Timer Bank

This block holds four independent 32-bit down-counters behind a flat register bus: a byte address, a write strobe, write data and a read-data return. Each counter gets a 64-byte bank holding its own registers. These are a preset, a run/stop bit, a mode bit, a restart strobe, the live count, an interrupt flag with a clear handshake, and a mask. Each channel drives its own interrupt line.

Software programs a preset, picks continuous or single-shot operation and starts the channel. In continuous mode the channel makes a periodic tick. In single-shot mode it fires once and stops. An expiry raises the channel's flag. Software clears the flag through a two-cycle handshake and polls a busy bit while it runs. A status word, readable at the start of every bank, gathers the four raw flags in one read.

All logic runs on one clock. The active-low reset asserts asynchronously and is released through a two-stage synchroniser. Reads are combinational. Writes take effect at the clock edge where the strobe is high.

Top module: `tmr_bank`

## Requirements
- R1: Channel n owns byte addresses n*0x40 to n*0x40+0x3F. The bank offsets are: mode 0x04 (bit 0), preset 0x08 (32 bits), run 0x10 (bit 0), restart 0x14 (write only, reads 0), count 0x18 (read only), clear 0x20, mask 0x24 (bit 0). Read data is valid in the same cycle as the address. Unused bits and unmapped offsets read 0.
- R2: After reset, every count, preset, mode, run bit and flag is 0, and every mask bit is 1.
- R3: A write to the preset register changes only the preset. The live count is not touched.
- R4: A write to the restart register, whatever its data, loads the preset into the count at that edge. This overrides the decrement.
- R5: While the run bit is 1 and the count is non-zero, the count drops by one per clock. When a running count is 0, the next edge sets the flag. With preset P, an expiry therefore occurs every P+1 cycles.
- R6: With mode bit 0 equal to 0 (continuous), an expiry also reloads the preset and leaves the run bit at 1.
- R7: With mode bit 0 equal to 1 (single-shot), an expiry leaves the count at 0 and clears the run bit.
- R8: Writing 1 to run bit 0 starts the channel and writing 0 stops it. A stopped count holds its value.
- R9: The clear register reads the flag in bit 0 and the busy bit in bit 1. Writing 1 to bit 0 makes busy read 1 for exactly two cycles, and the flag reads 0 when busy falls. Writing 0 to bit 0 has no effect.
- R10: A clear write made while busy is 1 is ignored and does not extend the busy time.
- R11: Offset 0x00 of any bank reads the raw flags of channels 0 to 3 in bits 0 to 3.
- R12: irq_o[n] is 1 exactly when channel n's flag is 1 and its mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert |
| bus_addr_i | input | 8 | Byte address: bits 7:6 select the channel, bits 5:0 the offset |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data |
| irq_o | output | 4 | Per-channel interrupt, flag and not mask |

## Verification
Read data is due in the same cycle as the address, so the bench samples it one time step after it drives the address. The effect of a write shows on the first falling edge after the rising edge that captured it. A running count changes once per rising edge, and the flag rises one edge after the count reads 0. The checks therefore step one falling edge at a time and compare against counts worked out by hand from the preset. For the clear handshake, busy must read 1 on the two falling edges after the clear write and 0 on the third; a second clear write landing on the first busy cycle would stretch that window and show up in the third read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_CH  = 4;
  localparam int DW      = 32;
  localparam int OFF_W   = 6;
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int AW      = CH_W + OFF_W;
  localparam int CLR_CYC = 2;

  localparam logic [OFF_W-1:0] OFF_STAT   = 6'h00;
  localparam logic [OFF_W-1:0] OFF_MODE   = 6'h04;
  localparam logic [OFF_W-1:0] OFF_LOAD   = 6'h08;
  localparam logic [OFF_W-1:0] OFF_RUN    = 6'h10;
  localparam logic [OFF_W-1:0] OFF_RELOAD = 6'h14;
  localparam logic [OFF_W-1:0] OFF_COUNT  = 6'h18;
  localparam logic [OFF_W-1:0] OFF_CLR    = 6'h20;
  localparam logic [OFF_W-1:0] OFF_MASK   = 6'h24;

  typedef enum logic {
    MODE_CONT   = 1'b0,
    MODE_SINGLE = 1'b1
  } tmr_mode_e;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW      = tmr_pkg::DW,
  parameter int OW      = tmr_pkg::OFF_W,
  parameter int CLR_LEN = tmr_pkg::CLR_CYC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [OW-1:0] off_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] rdata_o,
  output logic          flag_o,
  output logic          irq_o
);
  localparam int BW = $clog2(CLR_LEN + 1);

  tmr_mode_e mode_q, mode_d;
  logic [CW-1:0] preset_q, preset_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          flag_q, flag_d;
  logic          mask_q, mask_d;
  logic [BW-1:0] busy_q, busy_d;
  logic          expire;
  logic          busy;

  assign expire = run_q && (cnt_q == '0);
  assign busy   = (busy_q != '0);

  // next-state logic
  always_comb begin
    mode_d   = mode_q;
    preset_d = preset_q;
    cnt_d    = cnt_q;
    run_d    = run_q;
    flag_d   = flag_q;
    mask_d   = mask_q;
    busy_d   = busy_q;

    if (run_q) begin
      if (cnt_q != '0)              cnt_d = cnt_q - 1'b1;
      else if (mode_q == MODE_CONT) cnt_d = preset_q;
      else                          run_d = 1'b0;
    end

    if (busy) begin
      busy_d = busy_q - 1'b1;
      if (busy_q == BW'(1)) flag_d = 1'b0;
    end
    if (expire) flag_d = 1'b1;

    if (wr_en_i) begin
      case (off_i)
        OFF_MODE:   mode_d   = tmr_mode_e'(wdata_i[0]);
        OFF_LOAD:   preset_d = wdata_i;
        OFF_RUN:    run_d    = wdata_i[0];
        OFF_RELOAD: cnt_d    = preset_q;
        OFF_CLR:    if (wdata_i[0] && !busy) busy_d = BW'(CLR_LEN);
        OFF_MASK:   mask_d   = wdata_i[0];
        default:    ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_CONT;
      preset_q <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      flag_q   <= 1'b0;
      mask_q   <= 1'b1;
      busy_q   <= '0;
    end else begin
      mode_q   <= mode_d;
      preset_q <= preset_d;
      cnt_q    <= cnt_d;
      run_q    <= run_d;
      flag_q   <= flag_d;
      mask_q   <= mask_d;
      busy_q   <= busy_d;
    end
  end

  // local read mux
  always_comb begin
    rdata_o = '0;
    case (off_i)
      OFF_MODE:  rdata_o = CW'(mode_q);
      OFF_LOAD:  rdata_o = preset_q;
      OFF_RUN:   rdata_o = CW'(run_q);
      OFF_COUNT: rdata_o = cnt_q;
      OFF_CLR:   rdata_o = CW'({busy, flag_q});
      OFF_MASK:  rdata_o = CW'(mask_q);
      default:   rdata_o = '0;
    endcase
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ~mask_q;

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q != '0 && !wr_en_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5
  AST_CONT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && mode_q == MODE_CONT && !wr_en_i) |=> (run_q && flag_q && cnt_q == $past(preset_q))); // R6
  AST_SINGLE_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && mode_q == MODE_SINGLE && !wr_en_i) |=> (!run_q && flag_q && cnt_q == '0)); // R7
  AST_CLR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |=> busy); // R9
  AST_CLR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q == BW'(1) && !expire) |=> !flag_q); // R9
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux #(
  parameter int NCH = tmr_pkg::NUM_CH,
  parameter int W   = tmr_pkg::DW,
  parameter int OW  = tmr_pkg::OFF_W,
  localparam int IW = $clog2(NCH)
) (
  input  logic [IW+OW-1:0]      addr_i,
  input  logic [NCH-1:0][W-1:0] ch_rdata_i,
  input  logic [NCH-1:0]        flags_i,
  output logic [W-1:0]          rdata_o
);
  logic [IW-1:0] idx;
  logic [OW-1:0] off;

  assign idx = addr_i[IW+OW-1:OW];
  assign off = addr_i[OW-1:0];

  always_comb begin
    if (off == tmr_pkg::OFF_STAT)  rdata_o = W'(flags_i);
    else if (int'(idx) < NCH)      rdata_o = ch_rdata_i[idx];
    else                           rdata_o = '0;
  end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NCH     = tmr_pkg::NUM_CH,
  parameter int W       = tmr_pkg::DW,
  parameter int OW      = tmr_pkg::OFF_W,
  parameter int CLR_LEN = tmr_pkg::CLR_CYC,
  localparam int IW     = $clog2(NCH),
  localparam int ADW    = IW + OW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [ADW-1:0] bus_addr_i,
  input  logic           bus_we_i,
  input  logic [W-1:0]   bus_wdata_i,
  output logic [W-1:0]   bus_rdata_o,
  output logic [NCH-1:0] irq_o
);
  logic                  rst_n;
  logic [NCH-1:0][W-1:0] ch_rdata;
  logic [NCH-1:0]        flag_w;
  logic [NCH-1:0]        wr_sel;

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign wr_sel[g] = bus_we_i && (bus_addr_i[ADW-1:OW] == IW'(g));

    tmr_channel #(.CW(W), .OW(OW), .CLR_LEN(CLR_LEN)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_n),
      .wr_en_i (wr_sel[g]),
      .off_i   (bus_addr_i[OW-1:0]),
      .wdata_i (bus_wdata_i),
      .rdata_o (ch_rdata[g]),
      .flag_o  (flag_w[g]),
      .irq_o   (irq_o[g])
    );
  end

  tmr_rdmux #(.NCH(NCH), .W(W), .OW(OW)) u_rd (
    .addr_i     (bus_addr_i),
    .ch_rdata_i (ch_rdata),
    .flags_i    (flag_w),
    .rdata_o    (bus_rdata_o)
  );

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((irq_o & ~flag_w) == '0)); // R12
  AST_ONE_WRITE_SEL: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(wr_sel)); // R1
endmodule

// File: tb/tmr_bank_tb.sv
module tmr_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  int          checks = 0;
  int          failures = 0;

  always #5 clk = ~clk;

  tmr_bank dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_addr_i  (addr),
    .bus_we_i    (we),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  // {is_write, addr, data, expected read}
  localparam logic [72:0] VEC [0:10] = '{
    {1'b1, 8'hC8, 32'hDEADBEEF, 32'h0},
    {1'b0, 8'hC8, 32'h0, 32'hDEADBEEF},
    {1'b1, 8'hC4, 32'hFFFFFFFF, 32'h0},
    {1'b0, 8'hC4, 32'h0, 32'h00000001},
    {1'b1, 8'hE4, 32'h0, 32'h0},
    {1'b0, 8'hE4, 32'h0, 32'h0},
    {1'b1, 8'h88, 32'h12345678, 32'h0},
    {1'b0, 8'h98, 32'h0, 32'h0},
    {1'b1, 8'h94, 32'h0, 32'h0},
    {1'b0, 8'h98, 32'h0, 32'h12345678},
    {1'b0, 8'hD8, 32'h0, 32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(4);

    // reset state
    rd_chk("R2 count", 8'h18, 32'h0);
    rd_chk("R2 mask", 8'h24, 32'h1);
    rd_chk("R11 status", 8'h00, 32'h0);
    chk("R12 irq", {28'h0, irq}, 32'h0);

    // table walk: R1 addressing, R3 preset only, R4 restart with data 0
    for (int i = 0; i < 11; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      else            rd_chk("R1/R3/R4 table", VEC[i][71:64], VEC[i][31:0]);
    end

    // ch0 continuous
    wr(8'h08, 32'd5);
    wr(8'h24, 32'd0);
    wr(8'h04, 32'd0);
    wr(8'h14, 32'd1);
    wr(8'h10, 32'd1);
    rd_chk("R8 start", 8'h18, 32'd5);
    for (int k = 1; k <= 5; k++) begin
      step(1);
      rd_chk("R5 decrement", 8'h18, 32'(5 - k));
    end
    rd_chk("R5 flag not yet", 8'h20, 32'h0);
    step(1);
    rd_chk("R6 reload", 8'h18, 32'd5);
    rd_chk("R5 flag", 8'h20, 32'h1);
    rd_chk("R6 still running", 8'h10, 32'h1);
    chk("R12 irq0", {28'h0, irq}, 32'h1);
    step(2);
    rd_chk("R6 counting", 8'h18, 32'd3);
    wr(8'h14, 32'd0);
    rd_chk("R4 restart", 8'h18, 32'd5);
    wr(8'h10, 32'd0);
    rd_chk("R8 stop", 8'h18, 32'd4);
    step(3);
    rd_chk("R8 hold", 8'h18, 32'd4);

    // ch0 clear
    wr(8'h20, 32'd0);
    step(2);
    rd_chk("R9 zero write", 8'h20, 32'h1);
    wr(8'h20, 32'd1);
    rd_chk("R9 busy 1st", 8'h20, 32'h3);
    step(1);
    rd_chk("R9 busy 2nd", 8'h20, 32'h3);
    step(1);
    rd_chk("R9 cleared", 8'h20, 32'h0);
    chk("R12 irq0 low", {28'h0, irq}, 32'h0);

    // ch1 single-shot
    wr(8'h48, 32'd2);
    wr(8'h44, 32'd1);
    wr(8'h54, 32'd0);
    wr(8'h50, 32'd1);
    rd_chk("R7 start", 8'h58, 32'd2);
    step(1);
    rd_chk("R7 step", 8'h58, 32'd1);
    step(1);
    rd_chk("R7 zero", 8'h58, 32'd0);
    step(1);
    rd_chk("R7 flag", 8'h60, 32'h1);
    rd_chk("R7 run cleared", 8'h50, 32'h0);
    step(2);
    rd_chk("R7 stays zero", 8'h58, 32'd0);
    rd_chk("R11 status any bank", 8'h80, 32'h2);
    chk("R12 masked", {28'h0, irq}, 32'h0);
    wr(8'h64, 32'd0);
    chk("R12 unmasked", {28'h0, irq}, 32'h2);

    // R10 write during busy ignored
    wr(8'h60, 32'd1);
    rd_chk("R10 busy 1st", 8'h60, 32'h3);
    wr(8'h60, 32'd1);
    rd_chk("R10 busy 2nd", 8'h60, 32'h3);
    step(1);
    rd_chk("R10 not extended", 8'h60, 32'h0);
    chk("R12 irq1 low", {28'h0, irq}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule